// File: doc/BRIEF.md
# Multi-Page-Size Data TLB

This block translates data virtual addresses to physical addresses through one fully associative array whose entries may each cover a different page granularity. Every entry holds a virtual page tag, a two-bit size code, a physical frame number and four permission bits. The size code tells the compare logic how many low page-number bits to ignore, so a single entry can map a large contiguous region. An 8 KB, 64 KB, 256 KB or 4 MB mapping therefore sits next to the others in the same array.

A lookup presents a 43-bit virtual address together with the access type, which is read or write and user or kernel. One cycle later the block returns a hit flag, the 34-bit physical address, a protection fault flag and a multi-hit flag. Miss handling software loads a mapping through the fill port. The entry it overwrites is chosen by a round-robin pointer inside the block. A single-cycle invalidate-all pulse removes every mapping at once.

Top module: `dtlb_multisize`

## Requirements
- R1: After a synchronous reset, no entry is valid, and `rsp_valid`, `rsp_hit`, `rsp_fault` and `rsp_multi` are 0.
- R2: `rsp_valid` is 1 in exactly the cycle after a cycle with `lk_valid` = 1, and is 0 otherwise.
- R3: For a size-0 (8 KB) entry, a lookup whose VA bits 42:13 equal the stored tag hits, and `rsp_pa` = {stored frame, VA[12:0]}.
- R4: Size codes 1, 2 and 3 ignore the low 3, 5 and 9 page-number bits (VA bits above 12) in the compare. The matching low bits of `rsp_pa` above bit 12 come from the VA, and the higher bits come from the stored frame.
- R5: A lookup that matches no valid entry returns `rsp_hit` = 0, `rsp_pa` = 0, `rsp_fault` = 0 and `rsp_multi` = 0.
- R6: On a hit, the permission bit at index {lk_user, lk_write} must be 1, or else `rsp_fault` = 1. The permission bits are: bit 0 kernel read, bit 1 kernel write, bit 2 user read, bit 3 user write.
- R7: When more than one valid entry matches, the lowest-numbered entry supplies the result and `rsp_multi` = 1. With a single match, `rsp_multi` = 0.
- R8: Each accepted fill writes the entry at the replacement pointer and then advances the pointer by one, wrapping after the last entry. After ENTRIES further fills, the oldest of them has been replaced.
- R9: `inv_all` clears every entry in one cycle. A lookup in the same cycle misses, and a fill in the same cycle is dropped.
- R10: A lookup in the same cycle as a fill sees the array contents from before that fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | 43 | Virtual address to translate |
| lk_write | input | 1 | Access is a write |
| lk_user | input | 1 | Access is from user mode |
| fill_en | input | 1 | Write one mapping |
| fill_vpn | input | 30 | Virtual page number (VA bits 42:13) of the mapping |
| fill_size | input | 2 | Page size code: 0=8 KB, 1=64 KB, 2=256 KB, 3=4 MB |
| fill_pfn | input | 21 | Physical frame number (PA bits 33:13) |
| fill_perm | input | 4 | Permission bits, laid out as in R6 |
| inv_all | input | 1 | Invalidate every entry |
| rsp_valid | output | 1 | Result of the previous cycle's lookup is present |
| rsp_hit | output | 1 | Lookup hit |
| rsp_pa | output | 34 | Translated physical address |
| rsp_fault | output | 1 | Access not permitted by the selected entry |
| rsp_multi | output | 1 | More than one entry matched |

## Verification
The clocked assertions assume that reset is held for at least one cycle before the first request, and that every input carries a known value at each clock edge once reset is released. They do not assume that mappings are disjoint, because overlapping fills are how the multi-hit path is reached. The bench drives each input only just after a falling edge and returns it to idle within one cycle. It places overlapping mappings in the array on purpose, and it lines up fills, lookups and invalidates in the same cycle only in the scenarios that are meant to check those collisions.

// File: rtl/dtlb_pkg.sv
package dtlb_pkg;

  typedef enum logic [1:0] {
    PG_8K   = 2'd0,
    PG_64K  = 2'd1,
    PG_256K = 2'd2,
    PG_4M   = 2'd3
  } pg_size_e;

  localparam int PERM_W = 4;

  // number of page-number bits above the base offset that a size ignores
  function automatic int unsigned skip_bits(pg_size_e s);
    case (s)
      PG_64K:  return 3;
      PG_256K: return 5;
      PG_4M:   return 9;
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] skip_mask(pg_size_e s);
    return (32'd1 << skip_bits(s)) - 32'd1;
  endfunction

endpackage

// File: rtl/dtlb_victim.sv
module dtlb_victim #(
  parameter int N = 32,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  output logic [IDX_W-1:0] ptr
);

  always_ff @(posedge clk) begin
    if (rst)
      ptr <= '0;
    else if (adv)
      ptr <= (ptr == IDX_W'(N - 1)) ? '0 : ptr + IDX_W'(1);
  end

  // pointer only moves on an accepted fill
  assert_ptr_holds_R8: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(ptr));

  assert_ptr_in_range_R8: assert property (@(posedge clk) disable iff (rst)
    ptr <= IDX_W'(N - 1));

endmodule

// File: rtl/dtlb_entry.sv
module dtlb_entry
  import dtlb_pkg::*;
#(
  parameter int VPN_W = 30,
  parameter int PFN_W = 21
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inv,
  input  logic              wr,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  pg_size_e          wr_size,
  input  logic [PFN_W-1:0]  wr_pfn,
  input  logic [PERM_W-1:0] wr_perm,
  input  logic [VPN_W-1:0]  lk_vpn,
  output logic              match,
  output logic [PFN_W-1:0]  pa_hi,
  output logic [PERM_W-1:0] perm
);

  logic              vld_q;
  logic [VPN_W-1:0]  tag_q;
  pg_size_e          size_q;
  logic [PFN_W-1:0]  pfn_q;
  logic [PERM_W-1:0] perm_q;

  always_ff @(posedge clk) begin
    if (rst || inv)
      vld_q <= 1'b0;
    else if (wr)
      vld_q <= 1'b1;
  end

  // payload carries no reset: it is qualified by vld_q
  always_ff @(posedge clk) begin
    if (wr && !inv) begin
      tag_q  <= wr_vpn;
      size_q <= wr_size;
      pfn_q  <= wr_pfn;
      perm_q <= wr_perm;
    end
  end

  logic [31:0]      m;
  logic [VPN_W-1:0] vign;
  logic [PFN_W-1:0] pign;

  always_comb begin
    m     = skip_mask(size_q);
    vign  = VPN_W'(m);
    pign  = PFN_W'(m);
    match = vld_q && (((lk_vpn ^ tag_q) & ~vign) == '0);
    pa_hi = (pfn_q & ~pign) | (lk_vpn[PFN_W-1:0] & pign);
    perm  = perm_q;
  end

endmodule

// File: rtl/dtlb_pick.sv
module dtlb_pick
  import dtlb_pkg::*;
#(
  parameter int N     = 32,
  parameter int PFN_W = 21
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N-1:0]      match,
  input  logic [PFN_W-1:0]  pa_hi [N],
  input  logic [PERM_W-1:0] perm  [N],
  output logic              any,
  output logic              multi,
  output logic [PFN_W-1:0]  sel_pa_hi,
  output logic [PERM_W-1:0] sel_perm
);

  logic [N-1:0] grant;

  always_comb begin
    grant     = match & (~match + N'(1));
    any       = |match;
    multi     = |(match & ~grant);
    sel_pa_hi = '0;
    sel_perm  = '0;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) begin
        sel_pa_hi = sel_pa_hi | pa_hi[i];
        sel_perm  = sel_perm | perm[i];
      end
    end
  end

  // lowest match wins: at most one grant
  assert_one_grant_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  assert_grant_when_match_R7: assert property (@(posedge clk) disable iff (rst)
    any |-> $countones(grant) == 1);

  assert_multi_needs_two_R7: assert property (@(posedge clk) disable iff (rst)
    multi |-> $countones(match) > 1);

endmodule

// File: rtl/dtlb_multisize.sv
module dtlb_multisize
  import dtlb_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int VA_W    = 43,
  parameter int PA_W    = 34,
  parameter int OFS_W   = 13,
  localparam int VPN_W  = VA_W - OFS_W,
  localparam int PFN_W  = PA_W - OFS_W,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  input  logic [VA_W-1:0]   lk_va,
  input  logic              lk_write,
  input  logic              lk_user,
  input  logic              fill_en,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [1:0]        fill_size,
  input  logic [PFN_W-1:0]  fill_pfn,
  input  logic [PERM_W-1:0] fill_perm,
  input  logic              inv_all,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [PA_W-1:0]   rsp_pa,
  output logic              rsp_fault,
  output logic              rsp_multi
);

  logic              fill_ok;
  logic [IDX_W-1:0]  ptr;
  logic [VPN_W-1:0]  lk_vpn;
  logic [ENTRIES-1:0] wr_sel;
  logic [ENTRIES-1:0] match;
  logic [PFN_W-1:0]  pa_hi  [ENTRIES];
  logic [PERM_W-1:0] perm_v [ENTRIES];
  logic              any, multi;
  logic [PFN_W-1:0]  sel_pa_hi;
  logic [PERM_W-1:0] sel_perm;

  assign fill_ok = fill_en && !inv_all;
  assign lk_vpn  = lk_va[VA_W-1:OFS_W];

  dtlb_victim #(.N(ENTRIES)) u_victim (
    .clk (clk),
    .rst (rst),
    .adv (fill_ok),
    .ptr (ptr)
  );

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    assign wr_sel[i] = fill_ok && (ptr == IDX_W'(i));
    dtlb_entry #(.VPN_W(VPN_W), .PFN_W(PFN_W)) u_ent (
      .clk     (clk),
      .rst     (rst),
      .inv     (inv_all),
      .wr      (wr_sel[i]),
      .wr_vpn  (fill_vpn),
      .wr_size (pg_size_e'(fill_size)),
      .wr_pfn  (fill_pfn),
      .wr_perm (fill_perm),
      .lk_vpn  (lk_vpn),
      .match   (match[i]),
      .pa_hi   (pa_hi[i]),
      .perm    (perm_v[i])
    );
  end

  dtlb_pick #(.N(ENTRIES), .PFN_W(PFN_W)) u_pick (
    .clk       (clk),
    .rst       (rst),
    .match     (match),
    .pa_hi     (pa_hi),
    .perm      (perm_v),
    .any       (any),
    .multi     (multi),
    .sel_pa_hi (sel_pa_hi),
    .sel_perm  (sel_perm)
  );

  logic lk_hit;
  assign lk_hit = lk_valid && any && !inv_all;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_pa    <= '0;
      rsp_fault <= 1'b0;
      rsp_multi <= 1'b0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= lk_hit;
      rsp_pa    <= lk_hit ? {sel_pa_hi, lk_va[OFS_W-1:0]} : '0;
      rsp_fault <= lk_hit && !sel_perm[{lk_user, lk_write}];
      rsp_multi <= lk_hit && multi;
    end
  end

  assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> rsp_valid);

  assert_rsp_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !rsp_valid && !rsp_hit);

  assert_inv_forces_miss_R9: assert property (@(posedge clk) disable iff (rst)
    inv_all |=> !rsp_hit);

  assert_fault_only_on_hit_R6: assert property (@(posedge clk) disable iff (rst)
    rsp_fault |-> rsp_hit);

  assert_multi_only_on_hit_R7: assert property (@(posedge clk) disable iff (rst)
    rsp_multi |-> rsp_hit);

  assert_miss_pa_zero_R5: assert property (@(posedge clk) disable iff (rst)
    !rsp_hit |-> rsp_pa == '0);

endmodule

// File: tb/test_dtlb_multisize.sv
module test_dtlb_multisize;

  logic        clk = 1'b0;
  logic        rst;
  logic        lk_valid, lk_write, lk_user;
  logic [42:0] lk_va;
  logic        fill_en;
  logic [29:0] fill_vpn;
  logic [1:0]  fill_size;
  logic [20:0] fill_pfn;
  logic [3:0]  fill_perm;
  logic        inv_all;
  logic        rsp_valid, rsp_hit, rsp_fault, rsp_multi;
  logic [33:0] rsp_pa;

  int n_chk = 0;
  int n_bad = 0;

  always #10ns clk = ~clk;

  dtlb_multisize i_dtlb_multisize (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_va(lk_va),
    .lk_write(lk_write), .lk_user(lk_user), .fill_en(fill_en),
    .fill_vpn(fill_vpn), .fill_size(fill_size), .fill_pfn(fill_pfn),
    .fill_perm(fill_perm), .inv_all(inv_all), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_pa(rsp_pa), .rsp_fault(rsp_fault),
    .rsp_multi(rsp_multi)
  );

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [33:0] exp_pa(logic [20:0] pfn, logic [29:0] vpn,
                                         int sz, logic [12:0] off);
    int k;
    logic [20:0] lowm;
    k = (sz == 1) ? 3 : (sz == 2) ? 5 : (sz == 3) ? 9 : 0;
    lowm = 21'((1 << k) - 1);
    return {(pfn & ~lowm) | (vpn[20:0] & lowm), off};
  endfunction

  task automatic idle();
    lk_valid = 0; lk_va = '0; lk_write = 0; lk_user = 0;
    fill_en = 0; fill_vpn = '0; fill_size = '0; fill_pfn = '0; fill_perm = '0;
    inv_all = 0;
  endtask

  // one cycle with any mix of operations; outputs sampled at the next falling edge
  task automatic step(bit lk, logic [29:0] vpn, logic [12:0] off, bit wr, bit usr,
                      bit fl, logic [29:0] fvpn, logic [1:0] fsz,
                      logic [20:0] fpfn, logic [3:0] fperm, bit inv);
    lk_valid = lk; lk_va = {vpn, off}; lk_write = wr; lk_user = usr;
    fill_en = fl; fill_vpn = fvpn; fill_size = fsz; fill_pfn = fpfn;
    fill_perm = fperm; inv_all = inv;
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic fill(logic [29:0] v, logic [1:0] s, logic [20:0] p, logic [3:0] pm);
    step(0, '0, '0, 0, 0, 1, v, s, p, pm, 0);
  endtask

  task automatic look(string req, logic [29:0] v, logic [12:0] off, bit wr, bit usr,
                      bit hit, logic [33:0] pa, bit fault, bit multi);
    step(1, v, off, wr, usr, 0, '0, '0, '0, '0, 0);
    chk(req, "rsp_valid", 64'(rsp_valid), 64'd1);
    chk(req, "rsp_hit",   64'(rsp_hit),   64'(hit));
    chk(req, "rsp_pa",    64'(rsp_pa),    64'(pa));
    chk(req, "rsp_fault", 64'(rsp_fault), 64'(fault));
    chk(req, "rsp_multi", 64'(rsp_multi), 64'(multi));
  endtask

  task automatic t_reset();
    rst = 1; idle();
    repeat (2) @(posedge clk);
    @(negedge clk); rst = 0;
    @(posedge clk); @(negedge clk);
    chk("R1", "rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R1", "rsp_hit",   64'(rsp_hit),   64'd0);
    chk("R1", "rsp_fault", 64'(rsp_fault), 64'd0);
    chk("R1", "rsp_multi", 64'(rsp_multi), 64'd0);
    look("R1", 30'h0123_4567, 13'h0, 0, 0, 0, '0, 0, 0);
  endtask

  task automatic t_base();
    fill(30'h0123_4567, 2'd0, 21'h0ABCD, 4'hF);
    look("R3", 30'h0123_4567, 13'h1A5, 0, 0, 1, {21'h0ABCD, 13'h1A5}, 0, 0);
    look("R5", 30'h0123_4566, 13'h1A5, 1, 1, 0, '0, 0, 0);
    @(negedge clk);
    chk("R2", "rsp_valid idle", 64'(rsp_valid), 64'd0);
  endtask

  task automatic t_sizes();
    fill(30'h0200_0008, 2'd1, 21'h11110, 4'hF);
    fill(30'h0300_0000, 2'd2, 21'h12340, 4'hF);
    fill(30'h0400_0000, 2'd3, 21'h0F000, 4'hF);
    look("R4 64K", 30'h0200_000F, 13'h0033, 0, 0, 1,
         exp_pa(21'h11110, 30'h0200_000F, 1, 13'h0033), 0, 0);
    look("R4 64K edge", 30'h0200_0010, 13'h0, 0, 0, 0, '0, 0, 0);
    look("R4 256K", 30'h0300_001F, 13'h1FFF, 0, 0, 1,
         exp_pa(21'h12340, 30'h0300_001F, 2, 13'h1FFF), 0, 0);
    look("R4 256K edge", 30'h0300_0020, 13'h0, 0, 0, 0, '0, 0, 0);
    look("R4 4M", 30'h0400_01FF, 13'h0007, 0, 0, 1,
         exp_pa(21'h0F000, 30'h0400_01FF, 3, 13'h0007), 0, 0);
    look("R4 4M edge", 30'h0400_0200, 13'h0, 0, 0, 0, '0, 0, 0);
  endtask

  task automatic t_perm();
    // perm 0101: kernel read and user read only
    fill(30'h0500_0000, 2'd0, 21'h00777, 4'b0101);
    look("R6 kr", 30'h0500_0000, 13'h10, 0, 0, 1, {21'h00777, 13'h10}, 0, 0);
    look("R6 kw", 30'h0500_0000, 13'h10, 1, 0, 1, {21'h00777, 13'h10}, 1, 0);
    look("R6 ur", 30'h0500_0000, 13'h10, 0, 1, 1, {21'h00777, 13'h10}, 0, 0);
    look("R6 uw", 30'h0500_0000, 13'h10, 1, 1, 1, {21'h00777, 13'h10}, 1, 0);
  endtask

  task automatic t_multi();
    // slot 5: 4 MB region; slot 6: 8 KB page inside it
    fill(30'h0600_0000, 2'd3, 21'h1A000, 4'hF);
    fill(30'h0600_0010, 2'd0, 21'h00042, 4'h0);
    look("R7 low wins", 30'h0600_0010, 13'h0, 1, 1, 1,
         exp_pa(21'h1A000, 30'h0600_0010, 3, 13'h0), 0, 1);
    look("R7 single", 30'h0600_0011, 13'h0, 0, 0, 1,
         exp_pa(21'h1A000, 30'h0600_0011, 3, 13'h0), 0, 0);
  endtask

  task automatic t_concurrent();
    step(1, 30'h0700_0000, 13'h0, 0, 0, 1, 30'h0700_0000, 2'd0, 21'h00100, 4'hF, 0);
    chk("R10", "hit during fill", 64'(rsp_hit), 64'd0);
    look("R10", 30'h0700_0000, 13'h4, 0, 0, 1, {21'h00100, 13'h4}, 0, 0);
  endtask

  task automatic t_inv();
    step(1, 30'h0123_4567, 13'h0, 0, 0, 0, '0, '0, '0, '0, 1);
    chk("R9", "rsp_valid", 64'(rsp_valid), 64'd1);
    chk("R9", "hit same cycle", 64'(rsp_hit), 64'd0);
    look("R9 cleared 8K", 30'h0123_4567, 13'h0, 0, 0, 0, '0, 0, 0);
    look("R9 cleared 4M", 30'h0400_0000, 13'h0, 0, 0, 0, '0, 0, 0);
    step(0, '0, '0, 0, 0, 1, 30'h0800_0000, 2'd0, 21'h00555, 4'hF, 1);
    look("R9 fill dropped", 30'h0800_0000, 13'h0, 0, 0, 0, '0, 0, 0);
  endtask

  task automatic t_rr();
    for (int i = 0; i < 32; i++)
      fill(30'h100 + 30'(i), 2'd0, 21'h200 + 21'(i), 4'hF);
    for (int i = 0; i < 32; i++)
      look("R8 all slots", 30'h100 + 30'(i), 13'h0, 0, 0, 1,
           {21'h200 + 21'(i), 13'h0}, 0, 0);
    fill(30'h0900_0000, 2'd0, 21'h00999, 4'hF);
    look("R8 oldest replaced", 30'h100, 13'h0, 0, 0, 0, '0, 0, 0);
    look("R8 next kept", 30'h101, 13'h0, 0, 0, 1, {21'h201, 13'h0}, 0, 0);
    look("R8 new entry", 30'h0900_0000, 13'h0, 0, 0, 1, {21'h00999, 13'h0}, 0, 0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_base();
    t_sizes();
    t_perm();
    t_multi();
    t_concurrent();
    t_inv();
    t_rr();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule